// File: doc/BRIEF.md
# I2C Target Address Router

This block sits behind an I2C target protocol engine. Each time that engine has captured the 7-bit address of a new transaction, the block chooses where the transaction goes. It can claim the transaction for the local register file. It can forward it across the control channel with the address left unchanged. It can forward it with the address rewritten from an alias to a physical remote target address. Otherwise it drops the transaction.

The local address is either a strapped value or a programmed one. The remote deserializer address sits in a register that software can write. That register also loads itself from a discovered value each time the link locks, unless software has frozen it. An alias and a physical target address together give a remapped path to one remote target. A pass-all switch forwards every address that is not local. A write-block switch stops writes that originate on the remote side from reaching the local registers.

The routing decision is registered. It appears one clock after the address strobe and stays unchanged until the next strobe.

Top module: `i2c_addr_router`

## Requirements
- R1: After reset, `route` is 2'b00, `fwd_addr` is 0 and `des_id` is 0.
- R2: The local address is `id_strap` when `id_from_reg` is 0 and `id_reg` when it is 1. An address equal to it gives route 2'b01 (local) with `fwd_addr` 0. The local address that is not selected is not treated as local.
- R3: When `des_id` is non-zero, an address equal to it gives route 2'b10 (forward) with `fwd_addr` equal to the address. When `des_id` is 0, no address matches it.
- R4: When `alias_id` is non-zero, an address equal to it gives route 2'b11 (forward-remapped) with `fwd_addr` equal to `rslave_id`. When `alias_id` is 0, no address matches it. The physical address `rslave_id` is not forwarded by itself.
- R5: When `pass_all` is 1, an address that matches no ID gives route 2'b10 with `fwd_addr` equal to the address. When `pass_all` is 0, such an address gives route 2'b00 (ignore) with `fwd_addr` 0.
- R6: When more than one rule matches, the local match wins. The deserializer match comes next, then the alias match, then pass-all.
- R7: A rising edge of `link_lock` loads `found_des_id` into `des_id` when `des_id_freeze` is 0, and changes nothing when it is 1. A `des_id_wr` pulse loads `des_id_wdata` whether or not the register is frozen. When a write and a load fall in the same cycle, the write wins.
- R8: When `remote_wr_block` is 1, a write (`rd_nwr`=0) with `from_remote`=1 to the local address gives route 2'b00. Reads from the remote side, writes from the local side and remote-side forwarding still route as normal.
- R9: `route` and `fwd_addr` change on the clock edge that samples `addr_vld`=1 and on no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_vld | input | 1 | One-cycle strobe: `addr_in` holds a new captured address |
| addr_in | input | 7 | Captured 7-bit target address |
| rd_nwr | input | 1 | Transfer direction: 1 read, 0 write |
| from_remote | input | 1 | 1 when the transaction arrived over the control channel |
| id_from_reg | input | 1 | Selects `id_reg` (1) or `id_strap` (0) as the local address |
| id_reg | input | 7 | Programmed local address |
| id_strap | input | 7 | Strapped local address |
| des_id_wr | input | 1 | Software write strobe for the deserializer address |
| des_id_wdata | input | 7 | Value written by `des_id_wr` |
| des_id_freeze | input | 1 | Blocks loading on link lock |
| rslave_id | input | 7 | Physical address of the remote target behind the alias |
| alias_id | input | 7 | Alias address of the remote target, 0 disables it |
| pass_all | input | 1 | Forward every address that is not local |
| remote_wr_block | input | 1 | Block remote-side writes to the local registers |
| link_lock | input | 1 | Control channel link locked |
| found_des_id | input | 7 | Deserializer address discovered over the link |
| route | output | 2 | 00 ignore, 01 local, 10 forward, 11 forward-remapped |
| fwd_addr | output | 7 | Address to forward, 0 when not forwarding |
| des_id | output | 7 | Current deserializer address register |

## Verification
The hardest case to reach is a lock edge that arrives in the same cycle as a software write. A second hard case is a lock edge that arrives while the register is frozen. The load fires only on the one edge where `link_lock` rises, so the bench drops lock and raises it again at a chosen falling clock edge, with the freeze bit and the write strobe already set up for that cycle. It then reads `des_id` on the following cycles to show that neither a late load nor a lost write took place. Overlapping matches are built by programming the local, deserializer and alias addresses to one shared value. The bench then moves them apart one at a time so that each rule of the priority order wins in turn.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {
    RT_IGNORE = 2'b00,
    RT_LOCAL  = 2'b01,
    RT_FWD    = 2'b10,
    RT_REMAP  = 2'b11
  } route_e;
endpackage

// File: rtl/local_id_sel.sv
module local_id_sel #(
  parameter int AW = i2c_rt_pkg::ADDR_W
) (
  input  logic          use_reg,
  input  logic [AW-1:0] reg_id,
  input  logic [AW-1:0] strap_id,
  output logic [AW-1:0] local_id
);
  // programmed value overrides the strap when selected
  assign local_id = use_reg ? reg_id : strap_id;
endmodule

// File: rtl/remote_id_reg.sv
module remote_id_reg #(
  parameter int AW = i2c_rt_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_lock,
  input  logic [AW-1:0] found_id,
  input  logic          freeze,
  input  logic          sw_wr,
  input  logic [AW-1:0] sw_data,
  output logic [AW-1:0] id_q
);
  logic lock_q;
  logic lock_rise;
  logic autoload;

  assign lock_rise = link_lock && !lock_q;
  // software write has precedence over a same-cycle autoload
  assign autoload  = lock_rise && !freeze && !sw_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      id_q   <= '0;
    end else begin
      lock_q <= link_lock;
      if (sw_wr)
        id_q <= sw_data;
      else if (autoload)
        id_q <= found_id;
    end
  end

  AST_FREEZE_KEEPS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !sw_wr) |=> $stable(id_q)); // R7
  AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (id_q == $past(sw_data))); // R7
  AST_LOCK_LOADS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (link_lock && !lock_q && !freeze && !sw_wr) |=> (id_q == $past(found_id))); // R7
  AST_NO_LOAD_WITHOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !(link_lock && !lock_q)) |=> $stable(id_q)); // R7
endmodule

// File: rtl/addr_route_dec.sv
module addr_route_dec
  import i2c_rt_pkg::*;
#(
  parameter int AW = i2c_rt_pkg::ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic          rd_nwr,
  input  logic          from_remote,
  input  logic [AW-1:0] local_id,
  input  logic [AW-1:0] des_id,
  input  logic [AW-1:0] slave_id,
  input  logic [AW-1:0] alias_id,
  input  logic          pass_all,
  input  logic          wr_block,
  output route_e        dec_route,
  output logic [AW-1:0] dec_fwd,
  output logic          hit_local,
  output logic          hit_des,
  output logic          hit_alias,
  output logic          local_blocked
);
  // address comparison; an all-zero ID may be defined to match nothing
  function automatic logic id_hit(input logic [AW-1:0] a,
                                  input logic [AW-1:0] id,
                                  input logic          zero_off);
    return (!zero_off || (id != '0)) && (a == id);
  endfunction

  assign hit_local     = id_hit(addr, local_id, 1'b0);
  assign hit_des       = id_hit(addr, des_id,   1'b1);
  assign hit_alias     = id_hit(addr, alias_id, 1'b1);
  assign local_blocked = hit_local && from_remote && !rd_nwr && wr_block;

  always_comb begin
    dec_route = RT_IGNORE;
    dec_fwd   = '0;
    if (hit_local) begin
      if (!local_blocked) dec_route = RT_LOCAL;
    end else if (hit_des) begin
      dec_route = RT_FWD;
      dec_fwd   = addr;
    end else if (hit_alias) begin
      dec_route = RT_REMAP;
      dec_fwd   = slave_id;
    end else if (pass_all) begin
      dec_route = RT_FWD;
      dec_fwd   = addr;
    end
  end
endmodule

// File: rtl/i2c_addr_router.sv
module i2c_addr_router
  import i2c_rt_pkg::*;
#(
  parameter int AW = i2c_rt_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_vld,
  input  logic [AW-1:0] addr_in,
  input  logic          rd_nwr,
  input  logic          from_remote,
  input  logic          id_from_reg,
  input  logic [AW-1:0] id_reg,
  input  logic [AW-1:0] id_strap,
  input  logic          des_id_wr,
  input  logic [AW-1:0] des_id_wdata,
  input  logic          des_id_freeze,
  input  logic [AW-1:0] rslave_id,
  input  logic [AW-1:0] alias_id,
  input  logic          pass_all,
  input  logic          remote_wr_block,
  input  logic          link_lock,
  input  logic [AW-1:0] found_des_id,
  output logic [1:0]    route,
  output logic [AW-1:0] fwd_addr,
  output logic [AW-1:0] des_id
);
  logic [AW-1:0] local_id;
  logic [AW-1:0] des_q;
  route_e        dec_route;
  logic [AW-1:0] dec_fwd;
  logic          hit_local, hit_des, hit_alias, local_blocked;
  logic [1:0]    route_q;
  logic [AW-1:0] fwd_q;

  local_id_sel #(.AW(AW)) u_lsel (
    .use_reg  (id_from_reg),
    .reg_id   (id_reg),
    .strap_id (id_strap),
    .local_id (local_id)
  );

  remote_id_reg #(.AW(AW)) u_desid (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_lock (link_lock),
    .found_id  (found_des_id),
    .freeze    (des_id_freeze),
    .sw_wr     (des_id_wr),
    .sw_data   (des_id_wdata),
    .id_q      (des_q)
  );

  addr_route_dec #(.AW(AW)) u_dec (
    .addr          (addr_in),
    .rd_nwr        (rd_nwr),
    .from_remote   (from_remote),
    .local_id      (local_id),
    .des_id        (des_q),
    .slave_id      (rslave_id),
    .alias_id      (alias_id),
    .pass_all      (pass_all),
    .wr_block      (remote_wr_block),
    .dec_route     (dec_route),
    .dec_fwd       (dec_fwd),
    .hit_local     (hit_local),
    .hit_des       (hit_des),
    .hit_alias     (hit_alias),
    .local_blocked (local_blocked)
  );

  // decision register: loads only on the strobe, holds otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= RT_IGNORE;
      fwd_q   <= '0;
    end else if (addr_vld) begin
      route_q <= dec_route;
      fwd_q   <= dec_fwd;
    end
  end

  assign route    = route_q;
  assign fwd_addr = fwd_q;
  assign des_id   = des_q;

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> ($stable(route) && $stable(fwd_addr))); // R9
  AST_LOCAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && hit_local && !local_blocked) |=> (route == 2'b01 && fwd_addr == '0)); // R6
  AST_BLOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && local_blocked) |=> (route == 2'b00)); // R8
  AST_DES_BEFORE_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && hit_des && !hit_local) |=> (route == 2'b10 && fwd_addr == $past(addr_in))); // R3
  AST_ALIAS_REMAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && hit_alias && !hit_des && !hit_local) |=>
      (route == 2'b11 && fwd_addr == $past(rslave_id))); // R4
  AST_REMAP_NEEDS_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && dec_route == RT_REMAP) |-> (alias_id != '0)); // R4
endmodule

// File: tb/tb_i2c_addr_router.sv
`timescale 1ns/1ps
module tb_i2c_addr_router;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       addr_vld;
  logic [6:0] addr_in;
  logic       rd_nwr, from_remote, id_from_reg;
  logic [6:0] id_reg, id_strap;
  logic       des_id_wr;
  logic [6:0] des_id_wdata;
  logic       des_id_freeze;
  logic [6:0] rslave_id, alias_id;
  logic       pass_all, remote_wr_block, link_lock;
  logic [6:0] found_des_id;
  logic [1:0] route;
  logic [6:0] fwd_addr, des_id;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  i2c_addr_router dut (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_in(addr_in),
    .rd_nwr(rd_nwr), .from_remote(from_remote), .id_from_reg(id_from_reg),
    .id_reg(id_reg), .id_strap(id_strap), .des_id_wr(des_id_wr),
    .des_id_wdata(des_id_wdata), .des_id_freeze(des_id_freeze),
    .rslave_id(rslave_id), .alias_id(alias_id), .pass_all(pass_all),
    .remote_wr_block(remote_wr_block), .link_lock(link_lock),
    .found_des_id(found_des_id), .route(route), .fwd_addr(fwd_addr),
    .des_id(des_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_rt(input string req, input logic [1:0] r, input logic [6:0] f);
    chk({req, " route"}, 32'(route), 32'(r));
    chk({req, " fwd"}, 32'(fwd_addr), 32'(f));
  endtask

  // strobe one address; returns at the falling edge after the sampling edge
  task automatic send(input logic [6:0] a, input logic rd, input logic rem);
    @(negedge clk);
    addr_in = a; rd_nwr = rd; from_remote = rem; addr_vld = 1'b1;
    @(negedge clk);
    addr_vld = 1'b0;
  endtask

  task automatic sw_write(input logic [6:0] v);
    @(negedge clk);
    des_id_wr = 1'b1; des_id_wdata = v;
    @(negedge clk);
    des_id_wr = 1'b0;
  endtask

  task automatic t_reset;
    expect_rt("R1", 2'b00, 7'h00);
    chk("R1 des_id", 32'(des_id), 32'h0);
  endtask

  task automatic t_local_select;
    id_strap = 7'h2A; id_reg = 7'h11; id_from_reg = 1'b0;
    send(7'h2A, 1'b0, 1'b0); expect_rt("R2 strap hit", 2'b01, 7'h00);
    send(7'h11, 1'b0, 1'b0); expect_rt("R2 reg unused", 2'b00, 7'h00);
    id_from_reg = 1'b1;
    send(7'h11, 1'b1, 1'b0); expect_rt("R2 reg hit", 2'b01, 7'h00);
    send(7'h2A, 1'b0, 1'b0); expect_rt("R2 strap unused", 2'b00, 7'h00);
  endtask

  task automatic t_des;
    sw_write(7'h30);
    chk("R3 des_id written", 32'(des_id), 32'h30);
    send(7'h30, 1'b0, 1'b0); expect_rt("R3 des hit", 2'b10, 7'h30);
    sw_write(7'h00);
    send(7'h00, 1'b0, 1'b0); expect_rt("R3 zero disables", 2'b00, 7'h00);
    send(7'h30, 1'b0, 1'b0); expect_rt("R3 old id gone", 2'b00, 7'h00);
  endtask

  task automatic t_alias;
    alias_id = 7'h50; rslave_id = 7'h22;
    send(7'h50, 1'b1, 1'b0); expect_rt("R4 alias remap", 2'b11, 7'h22);
    send(7'h22, 1'b0, 1'b0); expect_rt("R4 physical not fwd", 2'b00, 7'h00);
    alias_id = 7'h00;
    send(7'h00, 1'b0, 1'b0); expect_rt("R4 zero alias", 2'b00, 7'h00);
    send(7'h50, 1'b0, 1'b0); expect_rt("R4 alias off", 2'b00, 7'h00);
  endtask

  task automatic t_passall;
    pass_all = 1'b1;
    send(7'h77, 1'b0, 1'b0); expect_rt("R5 pass-all fwd", 2'b10, 7'h77);
    send(7'h11, 1'b0, 1'b0); expect_rt("R6 local over pass-all", 2'b01, 7'h00);
    pass_all = 1'b0;
    send(7'h77, 1'b0, 1'b0); expect_rt("R5 pass-all off", 2'b00, 7'h00);
  endtask

  task automatic t_priority;
    id_reg = 7'h40; alias_id = 7'h40; rslave_id = 7'h09;
    sw_write(7'h40);
    send(7'h40, 1'b0, 1'b0); expect_rt("R6 local first", 2'b01, 7'h00);
    id_reg = 7'h41;
    send(7'h40, 1'b0, 1'b0); expect_rt("R6 des over alias", 2'b10, 7'h40);
    sw_write(7'h00);
    send(7'h40, 1'b0, 1'b0); expect_rt("R6 alias next", 2'b11, 7'h09);
    pass_all = 1'b1;
    send(7'h40, 1'b0, 1'b0); expect_rt("R6 alias over pass-all", 2'b11, 7'h09);
    pass_all = 1'b0; alias_id = 7'h00; id_reg = 7'h11;
  endtask

  task automatic t_autoload;
    @(negedge clk);
    des_id_freeze = 1'b0; found_des_id = 7'h1C; link_lock = 1'b1;
    @(negedge clk);
    chk("R7 lock loads", 32'(des_id), 32'h1C);
    link_lock = 1'b0;
    @(negedge clk);
    des_id_freeze = 1'b1; found_des_id = 7'h3D; link_lock = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R7 frozen keeps", 32'(des_id), 32'h1C);
    sw_write(7'h05);
    chk("R7 write while frozen", 32'(des_id), 32'h05);
    send(7'h05, 1'b0, 1'b0); expect_rt("R7 written id used", 2'b10, 7'h05);
    @(negedge clk);
    des_id_freeze = 1'b0; link_lock = 1'b0;
    @(negedge clk);
    link_lock = 1'b1; found_des_id = 7'h66; des_id_wr = 1'b1; des_id_wdata = 7'h07;
    @(negedge clk);
    des_id_wr = 1'b0;
    chk("R7 write beats load", 32'(des_id), 32'h07);
    @(negedge clk);
    chk("R7 no late load", 32'(des_id), 32'h07);
    link_lock = 1'b0;
    sw_write(7'h00);
  endtask

  task automatic t_block;
    remote_wr_block = 1'b1; alias_id = 7'h50; rslave_id = 7'h22;
    send(7'h11, 1'b0, 1'b1); expect_rt("R8 remote write blocked", 2'b00, 7'h00);
    send(7'h11, 1'b1, 1'b1); expect_rt("R8 remote read ok", 2'b01, 7'h00);
    send(7'h11, 1'b0, 1'b0); expect_rt("R8 local write ok", 2'b01, 7'h00);
    send(7'h50, 1'b0, 1'b1); expect_rt("R8 remote fwd unaffected", 2'b11, 7'h22);
    remote_wr_block = 1'b0;
    send(7'h11, 1'b0, 1'b1); expect_rt("R8 block off", 2'b01, 7'h00);
    alias_id = 7'h00;
  endtask

  task automatic t_timing;
    send(7'h11, 1'b0, 1'b0); expect_rt("R9 setup", 2'b01, 7'h00);
    @(negedge clk);
    pass_all = 1'b1; addr_in = 7'h77; addr_vld = 1'b1;
    #1;
    expect_rt("R9 not before edge", 2'b01, 7'h00);
    @(negedge clk);
    addr_vld = 1'b0;
    expect_rt("R9 after edge", 2'b10, 7'h77);
    addr_in = 7'h11;
    repeat (3) @(negedge clk);
    expect_rt("R9 held", 2'b10, 7'h77);
    pass_all = 1'b0;
    repeat (2) @(negedge clk);
    expect_rt("R9 held after cfg change", 2'b10, 7'h77);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr_vld = 1'b0; addr_in = '0; rd_nwr = 1'b0;
    from_remote = 1'b0; id_from_reg = 1'b0; id_reg = '0; id_strap = '0;
    des_id_wr = 1'b0; des_id_wdata = '0; des_id_freeze = 1'b0;
    rslave_id = '0; alias_id = '0; pass_all = 1'b0; remote_wr_block = 1'b0;
    link_lock = 1'b0; found_des_id = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_local_select();
    t_des();
    t_alias();
    t_passall();
    t_priority();
    t_autoload();
    t_block();
    t_timing();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule